// File: doc/BRIEF.md
# GPIO Bank with Edge-Detect Interrupts

This block is one bank of 32 general-purpose pins attached to a simple memory-mapped register bus. Software selects each pin's direction, drives output levels, samples input levels, and arms per-pin detection of rising and falling edges. Direction, output level, and both edge-enable kinds are never written as a whole word. Each has a separate set address and a separate clear address. A 1 in the written word acts on that pin, and a 0 leaves the pin alone, so several agents can share the bank without read-modify-write races.

Detected edges collect in a sticky status word that software clears by writing 1s. A routing mask selects which status bits may raise the single level-sensitive interrupt toward the processor. Pin inputs are resynchronised through two flops before they are observed or compared for edges.

Top module: `gpio_edge_bank`

## Requirements
- R1: While reset is asserted, and until the first write after it, the block holds its reset state. All pins are inputs (`pin_oe` = 0) and `pin_out` = 0. `irq` = 0. Reads of direction (0x0C), rising enable (0x30), falling enable (0x3C) and edge status (0x48) return 0.
- R2: A write to 0x18 sets `pin_out` bit n for every written 1. A write to 0x24 clears those bits. Bits written as 0 keep their value. `pin_out` changes at the clock edge that accepts the write.
- R3: A write to 0x54 makes the selected pins outputs and a write to 0x60 makes them inputs. The direction word reads back at 0x0C, where 1 means output, and it drives `pin_oe` directly.
- R4: A read of 0x00 returns the pin levels after a two-flop synchroniser. A change on `pin_in` becomes visible there after two clock edges.
- R5: Rising-edge enables are set by writing 1s to 0x6C and cleared by writing 1s to 0x78. They read back at 0x30.
- R6: Falling-edge enables are set by writing 1s to 0x84 and cleared by writing 1s to 0x90. They read back at 0x3C. A pin may have both kinds enabled at once.
- R7: An edge on a synchronised pin sets status bit n (read at 0x48) one edge after it reaches the level register, but only if that edge kind is enabled for the pin. Edges that are not enabled leave the status unchanged.
- R8: Writing 1 to a bit at 0x48 clears that status bit. Writing 0 leaves it unchanged. A status bit otherwise stays set.
- R9: If an enabled edge and a write-1 clear of the same status bit fall in the same cycle, the bit ends up set.
- R10: Writing 1s to 0x9C adds pins to the interrupt routing mask, and writing 1s to 0xA8 removes them. Writing all ones to 0x9C routes every pin.
- R11: `irq` is high exactly when some status bit and its routing-mask bit are both 1. It follows the registered state with no extra delay.
- R12: `bus_rdata` is registered and valid in the cycle after `bus_re`. It is 0 otherwise. Reads of set or clear addresses and of unmapped addresses return 0. Writes to the read-only offsets 0x00, 0x0C, 0x30 and 0x3C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| pin_in | input | 32 | Raw pin input levels, asynchronous |
| pin_oe | output | 32 | Per-pin output enable, 1 = drive |
| pin_out | output | 32 | Per-pin output value |
| irq | output | 1 | Level interrupt toward the processor |

## Verification
The assertions assume that a write and a read never target the status word in a way that needs ordering beyond the cycle. A read in the same cycle as a write returns the value before the write. The assertions also assume that `pin_in` is stable while reset is released, so the synchroniser and edge history start from known values.

The stimulus drives every input at the falling clock edge and holds each strobe for one cycle. It holds `pin_in` at zero through reset. It arms edge enables only while the pins are quiet. It schedules the collision of an edge with a status clear by counting the three registers between the pin and the status bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned GB_DEC_W = 8;

    localparam logic [GB_DEC_W-1:0] OFS_LEVEL    = 8'h00;
    localparam logic [GB_DEC_W-1:0] OFS_DIR      = 8'h0C;
    localparam logic [GB_DEC_W-1:0] OFS_OUT_SET  = 8'h18;
    localparam logic [GB_DEC_W-1:0] OFS_OUT_CLR  = 8'h24;
    localparam logic [GB_DEC_W-1:0] OFS_RISE     = 8'h30;
    localparam logic [GB_DEC_W-1:0] OFS_FALL     = 8'h3C;
    localparam logic [GB_DEC_W-1:0] OFS_STAT     = 8'h48;
    localparam logic [GB_DEC_W-1:0] OFS_DIR_SET  = 8'h54;
    localparam logic [GB_DEC_W-1:0] OFS_DIR_CLR  = 8'h60;
    localparam logic [GB_DEC_W-1:0] OFS_RISE_SET = 8'h6C;
    localparam logic [GB_DEC_W-1:0] OFS_RISE_CLR = 8'h78;
    localparam logic [GB_DEC_W-1:0] OFS_FALL_SET = 8'h84;
    localparam logic [GB_DEC_W-1:0] OFS_FALL_CLR = 8'h90;
    localparam logic [GB_DEC_W-1:0] OFS_MASK_SET = 8'h9C;
    localparam logic [GB_DEC_W-1:0] OFS_MASK_CLR = 8'hA8;

    typedef enum logic [3:0] {
        RS_NONE, RS_LEVEL, RS_DIR, RS_OUT_SET, RS_OUT_CLR, RS_RISE, RS_FALL,
        RS_STAT, RS_DIR_SET, RS_DIR_CLR, RS_RISE_SET, RS_RISE_CLR,
        RS_FALL_SET, RS_FALL_CLR, RS_MASK_SET, RS_MASK_CLR
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [GB_DEC_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_LEVEL:    s = RS_LEVEL;
            OFS_DIR:      s = RS_DIR;
            OFS_OUT_SET:  s = RS_OUT_SET;
            OFS_OUT_CLR:  s = RS_OUT_CLR;
            OFS_RISE:     s = RS_RISE;
            OFS_FALL:     s = RS_FALL;
            OFS_STAT:     s = RS_STAT;
            OFS_DIR_SET:  s = RS_DIR_SET;
            OFS_DIR_CLR:  s = RS_DIR_CLR;
            OFS_RISE_SET: s = RS_RISE_SET;
            OFS_RISE_CLR: s = RS_RISE_CLR;
            OFS_FALL_SET: s = RS_FALL_SET;
            OFS_FALL_CLR: s = RS_FALL_CLR;
            OFS_MASK_SET: s = RS_MASK_SET;
            OFS_MASK_CLR: s = RS_MASK_CLR;
            default:      s = RS_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = din;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q.s2;

endmodule

// File: rtl/gpio_edge_stat.sv
module gpio_edge_stat #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] stat;
    } edge_t;

    edge_t edge_d, edge_q;
    logic [W-1:0] rise_hit, fall_hit, events;

    always_comb begin
        rise_hit    = level & ~edge_q.prev & rise_en;
        fall_hit    = ~level & edge_q.prev & fall_en;
        events      = rise_hit | fall_hit;
        edge_d      = edge_q;
        edge_d.prev = level;
        // a fresh event overrides a clear in the same cycle
        edge_d.stat = (edge_q.stat & ~clr_mask) | events;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
    end

    assign status = edge_q.stat;

    // R8: a set bit only drops when a write-1 clear targeted it
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(edge_q.stat) & ~$past(clr_mask)) & ~edge_q.stat) == '0);

    // R7: newly set bits must have had an enable one cycle earlier
    p_disabled_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((edge_q.stat & ~$past(edge_q.stat))
                  & ~($past(rise_en) | $past(fall_en))) == '0);

    // R9: an enabled rising edge meeting a clear leaves the bit set
    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask & level & ~edge_q.prev & rise_en) != '0)
        |=> (edge_q.stat & $past(clr_mask & level & ~edge_q.prev & rise_en))
            == $past(clr_mask & level & ~edge_q.prev & rise_en));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    input  logic              bus_re,
    input  logic [W-1:0]      level,
    input  logic [W-1:0]      status,
    output logic [W-1:0]      bus_rdata,
    output logic [W-1:0]      dir,
    output logic [W-1:0]      outv,
    output logic [W-1:0]      rise_en,
    output logic [W-1:0]      fall_en,
    output logic [W-1:0]      route_mask,
    output logic [W-1:0]      clr_mask
);

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] outv;
        logic [W-1:0] ren;
        logic [W-1:0] fen;
        logic [W-1:0] msk;
        logic [W-1:0] rdata;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e sel;
    logic     hi_zero;
    logic     strobe_addr;

    always_comb begin
        hi_zero = (bus_addr >> GB_DEC_W) == '0;
        sel     = hi_zero ? decode_sel(bus_addr[GB_DEC_W-1:0]) : RS_NONE;
        strobe_addr = !(sel inside {RS_NONE, RS_LEVEL, RS_DIR, RS_RISE, RS_FALL, RS_STAT});
    end

    always_comb begin
        regs_d       = regs_q;
        regs_d.rdata = '0;
        if (bus_re) begin
            case (sel)
                RS_LEVEL: regs_d.rdata = level;
                RS_DIR:   regs_d.rdata = regs_q.dir;
                RS_RISE:  regs_d.rdata = regs_q.ren;
                RS_FALL:  regs_d.rdata = regs_q.fen;
                RS_STAT:  regs_d.rdata = status;
                default:  regs_d.rdata = '0;
            endcase
        end
        if (bus_we) begin
            case (sel)
                RS_OUT_SET:  regs_d.outv = regs_q.outv | bus_wdata;
                RS_OUT_CLR:  regs_d.outv = regs_q.outv & ~bus_wdata;
                RS_DIR_SET:  regs_d.dir  = regs_q.dir | bus_wdata;
                RS_DIR_CLR:  regs_d.dir  = regs_q.dir & ~bus_wdata;
                RS_RISE_SET: regs_d.ren  = regs_q.ren | bus_wdata;
                RS_RISE_CLR: regs_d.ren  = regs_q.ren & ~bus_wdata;
                RS_FALL_SET: regs_d.fen  = regs_q.fen | bus_wdata;
                RS_FALL_CLR: regs_d.fen  = regs_q.fen & ~bus_wdata;
                RS_MASK_SET: regs_d.msk  = regs_q.msk | bus_wdata;
                RS_MASK_CLR: regs_d.msk  = regs_q.msk & ~bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign clr_mask   = (bus_we && sel == RS_STAT) ? bus_wdata : '0;
    assign bus_rdata  = regs_q.rdata;
    assign dir        = regs_q.dir;
    assign outv       = regs_q.outv;
    assign rise_en    = regs_q.ren;
    assign fall_en    = regs_q.fen;
    assign route_mask = regs_q.msk;

    // R3: every bit written to the direction-set address is an output afterwards
    p_dir_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == RS_DIR_SET) |=> (regs_q.dir & $past(bus_wdata)) == $past(bus_wdata));

    // R2: bits written to the output-clear address are low afterwards
    p_out_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == RS_OUT_CLR) |=> (regs_q.outv & $past(bus_wdata)) == '0);

    // R12: set/clear addresses read back as zero
    p_strobe_read_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && strobe_addr) |=> bus_rdata == '0);

    // R12: a write to the read-only direction offset changes nothing
    p_ro_dir_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == RS_DIR) |=> $stable(regs_q.dir));

    // R10: mask-set bits are routed afterwards
    p_mask_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == RS_MASK_SET) |=> (regs_q.msk & $past(bus_wdata)) == $past(bus_wdata));

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic              bus_re,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_out,
    output logic              irq
);

    logic [NPINS-1:0] level_w, status_w, rise_w, fall_w, mask_w, clr_w;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (level_w)
    );

    gpio_edge_stat #(.W(NPINS)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (level_w),
        .rise_en (rise_w),
        .fall_en (fall_w),
        .clr_mask(clr_w),
        .status  (status_w)
    );

    gpio_bank_regs #(.W(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .level     (level_w),
        .status    (status_w),
        .bus_rdata (bus_rdata),
        .dir       (pin_oe),
        .outv      (pin_out),
        .rise_en   (rise_w),
        .fall_en   (fall_w),
        .route_mask(mask_w),
        .clr_mask  (clr_w)
    );

    assign irq = |(status_w & mask_w);

    // R11: the interrupt needs some latched edge behind it
    p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_w != '0));

    // R11: with nothing routed the interrupt stays low
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w == '0) |-> !irq);

endmodule

// File: tb/gpio_edge_bank_bench.sv
module gpio_edge_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_oe, pin_out;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_edge_bank u_gpio_edge_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
    );

    // behavioural reference, updated on every rising edge
    logic [31:0] m_s1, m_s2, m_prev, m_dir, m_out, m_ren, m_fen, m_st, m_msk, m_rd;

    always @(posedge clk or negedge rst_n) begin
        logic [31:0] ev, clr, rd;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_dir = 0; m_out = 0;
            m_ren = 0; m_fen = 0; m_st = 0; m_msk = 0; m_rd = 0;
        end else begin
            ev  = (m_s2 & ~m_prev & m_ren) | (~m_s2 & m_prev & m_fen);
            clr = (bus_we && bus_addr == 8'h48) ? bus_wdata : 32'h0;
            rd  = 32'h0;
            if (bus_re) begin
                if (bus_addr == 8'h00) rd = m_s2;
                else if (bus_addr == 8'h0C) rd = m_dir;
                else if (bus_addr == 8'h30) rd = m_ren;
                else if (bus_addr == 8'h3C) rd = m_fen;
                else if (bus_addr == 8'h48) rd = m_st;
            end
            if (bus_we) begin
                if (bus_addr == 8'h18) m_out = m_out | bus_wdata;
                if (bus_addr == 8'h24) m_out = m_out & ~bus_wdata;
                if (bus_addr == 8'h54) m_dir = m_dir | bus_wdata;
                if (bus_addr == 8'h60) m_dir = m_dir & ~bus_wdata;
                if (bus_addr == 8'h6C) m_ren = m_ren | bus_wdata;
                if (bus_addr == 8'h78) m_ren = m_ren & ~bus_wdata;
                if (bus_addr == 8'h84) m_fen = m_fen | bus_wdata;
                if (bus_addr == 8'h90) m_fen = m_fen & ~bus_wdata;
                if (bus_addr == 8'h9C) m_msk = m_msk | bus_wdata;
                if (bus_addr == 8'hA8) m_msk = m_msk & ~bus_wdata;
            end
            m_st   = (m_st & ~clr) | ev;
            m_rd   = rd;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pin_in;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // model comparison on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 model pin_oe", pin_oe, m_dir);
            chk("R2 model pin_out", pin_out, m_out);
            chk("R11 model irq", {31'b0, irq}, {31'b0, |(m_st & m_msk)});
            chk("R12 model rdata", bus_rdata, m_rd);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle(4);
        chk("R1 reset pin_oe", pin_oe, 32'h0);
        chk("R1 reset pin_out", pin_out, 32'h0);
        chk("R1 reset irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        rd(8'h0C, 32'h0, "R1 dir after reset");
        rd(8'h30, 32'h0, "R1 rise enable after reset");
        rd(8'h3C, 32'h0, "R1 fall enable after reset");
        rd(8'h48, 32'h0, "R1 status after reset");

        wr(8'h54, 32'hF0F0_0000);
        wr(8'h60, 32'h3000_0000);
        rd(8'h0C, 32'hC0F0_0000, "R3 dir readback");
        chk("R3 pin_oe", pin_oe, 32'hC0F0_0000);

        wr(8'h18, 32'h0000_00FF);
        wr(8'h24, 32'h0000_000F);
        chk("R2 pin_out set/clear", pin_out, 32'h0000_00F0);
        wr(8'h0C, 32'hAAAA_AAAA);
        rd(8'h0C, 32'hC0F0_0000, "R12 write to read-only dir ignored");

        pin_in = 32'h1234_5678;
        idle(3);
        rd(8'h00, 32'h1234_5678, "R4 level after sync");
        rd(8'h18, 32'h0, "R12 set address reads zero");
        rd(8'hFC, 32'h0, "R12 unmapped reads zero");
        pin_in = 32'h0;
        idle(4);
        rd(8'h00, 32'h0, "R4 level back low");

        wr(8'h6C, 32'h0000_010F);
        wr(8'h78, 32'h0000_0003);
        wr(8'h84, 32'h0000_01F0);
        rd(8'h30, 32'h0000_010C, "R5 rise enable readback");
        rd(8'h3C, 32'h0000_01F0, "R6 fall enable readback");

        pin_in = 32'h0000_01FF;
        idle(4);
        rd(8'h48, 32'h0000_010C, "R7 only enabled rising edges latch");
        pin_in = 32'h0;
        idle(4);
        rd(8'h48, 32'h0000_01FC, "R6 falling edges latch, pin 8 both kinds");

        chk("R11 irq low with empty mask", {31'b0, irq}, 32'h0);
        wr(8'h9C, 32'h0000_0100);
        chk("R10 irq after routing pin 8", {31'b0, irq}, 32'h1);
        wr(8'hA8, 32'h0000_0100);
        chk("R10 irq after unrouting pin 8", {31'b0, irq}, 32'h0);

        wr(8'h48, 32'h0000_000C);
        rd(8'h48, 32'h0000_01F0, "R8 write-1 clears");
        wr(8'h48, 32'h0);
        rd(8'h48, 32'h0000_01F0, "R8 write-0 keeps");

        // R9: enabled rise on pin 2 reaches status in the same cycle as its clear
        @(negedge clk);
        pin_in = 32'h0000_0004;
        @(negedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h0000_0004;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        rd(8'h48, 32'h0000_01F4, "R9 event beats clear");

        wr(8'h9C, 32'hFFFF_FFFF);
        chk("R11 irq with full mask", {31'b0, irq}, 32'h1);
        wr(8'h48, 32'hFFFF_FFFF);
        chk("R11 irq after clearing all", {31'b0, irq}, 32'h0);
        rd(8'h48, 32'h0, "R8 status all cleared");

        idle(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule